// File: doc/BRIEF.md
# Delay-Line Propagation Depth Sensor

This block measures how fast the surrounding logic runs at the moment. A chain of identical inverting stages is fed by the clock itself. When the clock falls, a transition starts down the chain. Half a period later, on the rising edge, one capture flop per stage tap records how far that transition has got. The block turns the captured tap vector into a stage count, the depth, and presents it as an 8-bit reading. A reading is produced on every cycle once the pipeline is full.

Stage delay grows when the supply voltage drops or the die gets hotter. A smaller depth therefore means slower logic. A supply controller can compare the reading against a threshold and raise or lower the core voltage to keep the reading just above the point where timing fails.

In this code base the chain taps arrive on a plain input vector, so the stage delays themselves are outside the block.

The capture path runs through three registers:
- the tap capture register, which also applies polarity correction;
- a segmented first-zero encoder with a registered result;
- the output register, with its valid flag.

A small fill sequencer with four states decides when the reading becomes valid:
- `ST_EMPTY`: the state after reset.
- `ST_CAPTURED`: reached on the first clock without reset.
- `ST_ENCODED`: reached on the next clock.
- `ST_STREAMING`: reached on the third clock. The sequencer stays here until reset.

Reset is synchronous and returns the sequencer to `ST_EMPTY` from any state.

Top module: `dls_depth_sensor`

## Requirements
- R1: While reset is high at a rising edge, the reading becomes 0 and valid becomes 0 after that edge.
- R2: After reset is released, valid stays low for the first two rising edges. It is high from the third edge on and stays high until the next reset.
- R3: A tap vector present before rising edge n determines the reading shown after edge n+2. A new reading is taken every cycle.
- R4: A stage that the edge has reached reads 1 on an even tap and 0 on an odd tap. A stage that has not been reached reads the opposite value. Tap 0 is the stage nearest the chain input.
- R5: When all 128 stages have switched, the reading is 128.
- R6: When stage 0 has not switched, the reading is 0, whatever the other taps hold.
- R7: The reading is the index of the first unswitched stage counting from tap 0. Switched stages beyond a gap (a bubble) do not add to the count.
- R8: A valid reading never exceeds the number of stages.
- R9: A reset raised during streaming clears the reading and restarts the R2 warm-up sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also the chain launch signal |
| rst_i | input | 1 | Synchronous active-high reset |
| tap_i | input | 128 | Raw chain tap levels, bit 0 nearest the chain input |
| depth_o | output | 8 | Registered propagation depth in stages |
| valid_o | output | 1 | High when depth_o holds a reading |

## Verification
The hardest case to reach from the ports is a bubbled capture. In such a capture, switched stages appear beyond an unswitched one, so the count must stop at the gap and not at the last switched tap. The stimulus builds a clean wavefront pattern with the correct per-tap polarity, flips a single tap inside or beyond the switched region, and checks that the reading lands on the first gap. Pipeline alignment is shown by changing the tap pattern on every cycle and matching each reading to the pattern applied three edges earlier.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY     = 2'd0,
        ST_CAPTURED  = 2'd1,
        ST_ENCODED   = 2'd2,
        ST_STREAMING = 2'd3
    } fill_state_e;

endpackage

// File: rtl/dls_tap_capture.sv
module dls_tap_capture #(
    parameter int N_STAGES = 128
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [N_STAGES-1:0] tap_i,
    output logic [N_STAGES-1:0] reached_o
);

    logic [N_STAGES-1:0] raw_q;

    // sample taps on the rising edge, half a period after launch
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            raw_q <= '0;
        end else begin
            raw_q <= tap_i;
        end
    end

    // odd stages sit behind an odd number of inversions relative to stage 0
    for (genvar k = 0; k < N_STAGES; k++) begin : g_pol
        if ((k % 2) == 1) begin : g_odd
            assign reached_o[k] = ~raw_q[k];
        end else begin : g_even
            assign reached_o[k] = raw_q[k];
        end
    end

endmodule

// File: rtl/dls_depth_encoder.sv
module dls_depth_encoder #(
    parameter int N_STAGES = 128,
    parameter int SEG_W    = 16
) (
    input  logic                                clk_i,
    input  logic                                rst_i,
    input  logic [N_STAGES-1:0]                 reached_i,
    output logic [$clog2(N_STAGES+1)-1:0]       depth_o
);

    localparam int CNT_W = $clog2(N_STAGES + 1);
    localparam int N_SEG = N_STAGES / SEG_W;
    localparam int IDX_W = $clog2(SEG_W);

    logic [N_SEG-1:0]            seg_full;
    logic [N_SEG-1:0][IDX_W-1:0] seg_idx;
    logic [CNT_W-1:0]            depth_d;

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        logic [SEG_W-1:0] bits;
        logic [IDX_W-1:0] idx;

        assign bits        = reached_i[s*SEG_W +: SEG_W];
        assign seg_full[s] = &bits;

        // lowest unswitched position inside this segment
        always_comb begin
            idx = '0;
            for (int i = SEG_W - 1; i >= 0; i--) begin
                if (!bits[i]) begin
                    idx = IDX_W'(i);
                end
            end
        end

        assign seg_idx[s] = idx;
    end

    // first segment holding a gap wins; all full means the whole chain
    always_comb begin
        depth_d = CNT_W'(N_STAGES);
        for (int s = N_SEG - 1; s >= 0; s--) begin
            if (!seg_full[s]) begin
                depth_d = CNT_W'(s * SEG_W) + CNT_W'(seg_idx[s]);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            depth_o <= '0;
        end else begin
            depth_o <= depth_d;
        end
    end

endmodule

// File: rtl/dls_fill_seq.sv
module dls_fill_seq
    import dls_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output logic load_valid_o
);

    fill_state_e state_q;
    fill_state_e state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:     state_d = ST_CAPTURED;
            ST_CAPTURED:  state_d = ST_ENCODED;
            ST_ENCODED:   state_d = ST_STREAMING;
            ST_STREAMING: state_d = ST_STREAMING;
            default:      state_d = ST_EMPTY;
        endcase
    end

    // the encoder register holds a real reading from ST_ENCODED onward
    always_comb begin
        load_valid_o = 1'b0;
        unique case (state_q)
            ST_EMPTY:     load_valid_o = 1'b0;
            ST_CAPTURED:  load_valid_o = 1'b0;
            ST_ENCODED:   load_valid_o = 1'b1;
            ST_STREAMING: load_valid_o = 1'b1;
            default:      load_valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dls_depth_sensor.sv
module dls_depth_sensor #(
    parameter int N_STAGES = 128,
    parameter int SEG_W    = 16
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [N_STAGES-1:0]           tap_i,
    output logic [$clog2(N_STAGES+1)-1:0] depth_o,
    output logic                          valid_o
);

    localparam int CNT_W = $clog2(N_STAGES + 1);

    logic [N_STAGES-1:0] reached;
    logic [CNT_W-1:0]    enc_depth;
    logic                load_valid;

    dls_tap_capture #(
        .N_STAGES(N_STAGES)
    ) u_capture (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tap_i     (tap_i),
        .reached_o (reached)
    );

    dls_depth_encoder #(
        .N_STAGES(N_STAGES),
        .SEG_W   (SEG_W)
    ) u_encoder (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .reached_i (reached),
        .depth_o   (enc_depth)
    );

    dls_fill_seq u_seq (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .load_valid_o (load_valid)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            depth_o <= '0;
            valid_o <= 1'b0;
        end else begin
            depth_o <= load_valid ? enc_depth : '0;
            valid_o <= load_valid;
        end
    end

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
    parameter int N_STAGES = 128
) (
    input logic                          clk_i,
    input logic                          rst_i,
    input logic [N_STAGES-1:0]           tap_i,
    input logic [$clog2(N_STAGES+1)-1:0] depth_o,
    input logic                          valid_o
);

    logic [N_STAGES-1:0] all_reached_raw;
    logic [1:0]          warm_q;

    for (genvar k = 0; k < N_STAGES; k++) begin : g_pat
        assign all_reached_raw[k] = ((k % 2) == 0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        rst_i |=> (depth_o == '0 && !valid_o));

    assert_warmup_valid_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm_q == 2'd3) == valid_o);

    assert_valid_holds_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> valid_o);

    assert_full_chain_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && $past(tap_i, 3) == all_reached_raw) |-> depth_o == N_STAGES);

    assert_stage0_idle_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && $past(tap_i[0], 3) == 1'b0) |-> depth_o == '0);

    assert_depth_range_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> depth_o <= N_STAGES);

endmodule

bind dls_depth_sensor dls_checker #(.N_STAGES(N_STAGES)) u_dls_checker (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tap_i   (tap_i),
    .depth_o (depth_o),
    .valid_o (valid_o)
);

// File: tb/tb_dls_depth_sensor.sv
module tb_dls_depth_sensor;

    localparam int N = 128;

    logic         clk_i = 1'b0;
    logic         rst_i = 1'b1;
    logic [N-1:0] tap_i = '0;
    logic [7:0]   depth_o;
    logic         valid_o;

    int checks = 0;
    int errors = 0;

    dls_depth_sensor dut (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tap_i   (tap_i),
        .depth_o (depth_o),
        .valid_o (valid_o)
    );

    always #5 clk_i = ~clk_i;

    function automatic logic [N-1:0] pattern(int d);
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) begin
            v[k] = (k < d) ? ((k % 2) == 0) : ((k % 2) == 1);
        end
        return v;
    endfunction

    task automatic step();
        @(posedge clk_i);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        step();
        rst_i = 1'b0;
    endtask

    task automatic apply_and_read(logic [N-1:0] v, int exp, string req);
        tap_i = v;
        step(); step(); step();
        check(req, depth_o, exp);
        check({req, " valid"}, valid_o, 1);
    endtask

    task automatic t_reset();
        rst_i = 1'b1;
        tap_i = pattern(N);
        step(); step();
        check("R1 depth", depth_o, 0);
        check("R1 valid", valid_o, 0);
    endtask

    task automatic t_warmup();
        do_reset();
        tap_i = pattern(40);
        step();
        check("R2 edge1", valid_o, 0);
        step();
        check("R2 edge2", valid_o, 0);
        step();
        check("R2 edge3", valid_o, 1);
        check("R3 first reading", depth_o, 40);
        step();
        check("R2 held", valid_o, 1);
    endtask

    task automatic t_extremes();
        apply_and_read(pattern(N), N, "R5 full chain");
        apply_and_read(pattern(0), 0, "R6 none switched");
        apply_and_read(pattern(0) ^ 128'hFFFF_0000, 0, "R6 stage0 idle");
        apply_and_read(pattern(N), N, "R8 bound");
    endtask

    task automatic t_depths();
        apply_and_read(pattern(1), 1, "R4 depth 1");
        apply_and_read(pattern(16), 16, "R4 segment edge");
        apply_and_read(pattern(64), 64, "R4 depth 64");
        apply_and_read(pattern(127), 127, "R4 depth 127");
    endtask

    task automatic t_bubble();
        logic [N-1:0] v;
        v = pattern(60);
        v[25] = ~v[25];
        apply_and_read(v, 25, "R7 gap inside");
        v = pattern(10);
        v[40] = ~v[40];
        apply_and_read(v, 10, "R7 stray beyond");
    endtask

    task automatic t_latency();
        tap_i = pattern(5);
        step();
        tap_i = pattern(90);
        step();
        tap_i = pattern(33);
        step();
        check("R3 seq a", depth_o, 5);
        step();
        check("R3 seq b", depth_o, 90);
        step();
        check("R3 seq c", depth_o, 33);
    endtask

    task automatic t_midreset();
        rst_i = 1'b1;
        step();
        check("R9 depth cleared", depth_o, 0);
        check("R9 valid cleared", valid_o, 0);
        rst_i = 1'b0;
        tap_i = pattern(70);
        step();
        check("R9 edge1", valid_o, 0);
        step();
        check("R9 edge2", valid_o, 0);
        step();
        check("R9 edge3", valid_o, 1);
        check("R9 reading", depth_o, 70);
    endtask

    initial begin
        #1;
        t_reset();
        t_warmup();
        t_extremes();
        t_depths();
        t_bubble();
        t_latency();
        t_midreset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule